// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a memory-mapped master for a synchronous serial link, seen one word at a time. Software writes words into an eight-entry transmit queue through a data register. A transfer engine takes each word in turn and either hands it to an external word-level exchange port or, in loopback mode, returns it directly. The result of each exchange goes into an eight-entry receive queue, and software drains that queue by reading the same data register. The block does not generate a serial clock and has no line-level framing. Exchanges on the external port use a valid/ready request and a response strobe, and only one exchange is in flight at a time.

Software programs the word width, from 1 to 16 bits, in the first control register. Every word written for transmit and every word stored on receive is cut to that width. Status flags, a raw interrupt register, a mask register and a masked view give the queue levels. A single registered interrupt line goes high when a half-full threshold is crossed on an enabled source. An eight-byte identification window sits at the top of the 4 KiB address space. The bus is a plain register port: a read strobe captures the addressed value into a registered read-data output on the next clock edge.

Top module: `ssp_ctrl`

## Requirements
- R1: Synchronous reset empties both queues, clears the mask and loads a word-width field of 7. After reset, status (offset 0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x08, the mask (0x14) and masked (0x1C) registers read 0, and `irq` is low.
- R2: Control0 (offset 0x00) bits [3:0] hold N, and the word width is N+1 bits. A write to data (0x08) stores only the low N+1 bits, and every received word is cut to the same width.
- R3: A data write while the transmit queue holds 8 words is dropped and leaves the queue unchanged.
- R4: A data read while the receive queue is empty returns 0 and changes nothing.
- R5: Words are exchanged only while control1 (0x04) bit 1 (enable) is 1 and bit 2 (slave select, not supported) is 0. Otherwise they stay in the transmit queue.
- R6: With control1 bit 0 (loopback) set, each received word equals the transmitted word. The engine stalls while the receive queue holds 8 words, so no word is lost and none is overwritten.
- R7: With loopback clear, the engine presents one word on `xchg_req_*`, holds it until it is accepted, waits for `xchg_resp_valid`, and stores the masked response. No new word leaves the transmit queue while an exchange is outstanding.
- R8: Status bits are: 0 transmit queue empty, 1 transmit queue not full, 2 receive queue not empty, 3 receive queue full, 4 busy. Busy means the transmit queue is non-empty or an exchange is outstanding.
- R9: Raw interrupt bit 2 is 1 when the receive level is 4 or more. Raw bit 3 is 1 when the transmit level is 4 or less. The masked register is raw AND mask. `irq` is high one cycle after the masked value is non-zero.
- R10: Reads at 0xFE0 to 0xFFC return one identification byte per word, in the order 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: The prescaler register (0x10) keeps only its low 8 bits. The DMA control register (0x20) always reads 0. Writes to status, raw and masked have no effect.
- R12: Words leave the receive queue in the order they were written to the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid after the edge that takes the read |
| irq | output | 1 | Registered interrupt request |
| xchg_req_valid | output | 1 | A transmit word is presented |
| xchg_req_ready | input | 1 | The peer accepts the presented word |
| xchg_req_data | output | 16 | Presented transmit word |
| xchg_resp_valid | input | 1 | The peer returns the exchanged word |
| xchg_resp_data | input | 16 | Returned word |

## Verification
The hardest state to reach from the ports is a receive queue that is full while words are still waiting in the transmit queue, since that is when the engine has to stall. The bench gets there by filling the transmit queue with the port disabled and enabling loopback so the receive queue fills up. It then adds three more words and reads everything back, checking that the stalled words come out after the first eight in order. The half-full thresholds are swept by filling one queue a word at a time and draining the other a word at a time. An external peer with a fixed response delay checks the one-in-flight handshake on three back-to-back words.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [11:0] OFF_CTRL0 = 12'h000;
  localparam logic [11:0] OFF_CTRL1 = 12'h004;
  localparam logic [11:0] OFF_DATA  = 12'h008;
  localparam logic [11:0] OFF_STAT  = 12'h00C;
  localparam logic [11:0] OFF_PRESC = 12'h010;
  localparam logic [11:0] OFF_IMASK = 12'h014;
  localparam logic [11:0] OFF_RAW   = 12'h018;
  localparam logic [11:0] OFF_MIS   = 12'h01C;
  localparam logic [11:0] OFF_DMA   = 12'h020;

  typedef enum logic [1:0] {ENG_IDLE, ENG_REQ, ENG_WAIT} eng_state_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h22;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head_data,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];

  // R6 / R3: a queue is never written beyond its depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (level < LVL_W'(DEPTH)));
  // R4: an empty queue is never popped
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));
endmodule

// File: rtl/ssp_xfer_engine.sv
module ssp_xfer_engine
  import ssp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         loopback,
  input  logic         tx_avail,
  input  logic         rx_space,
  input  logic [W-1:0] tx_word,
  input  logic [W-1:0] word_mask,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_word,
  output logic         in_flight,
  output logic         req_valid,
  output logic [W-1:0] req_data,
  input  logic         req_ready,
  input  logic         resp_valid,
  input  logic [W-1:0] resp_data
);
  eng_state_t state;
  logic       start;

  assign start     = (state == ENG_IDLE) && run && tx_avail && rx_space;
  assign tx_pop    = start;
  assign rx_push   = (start && loopback) || ((state == ENG_WAIT) && resp_valid);
  assign rx_word   = (state == ENG_WAIT) ? (resp_data & word_mask) : (tx_word & word_mask);
  assign in_flight = (state != ENG_IDLE);
  assign req_valid = (state == ENG_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      req_data <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (start && !loopback) begin
          req_data <= tx_word;
          state    <= ENG_REQ;
        end
        ENG_REQ:  if (req_ready)  state <= ENG_WAIT;
        ENG_WAIT: if (resp_valid) state <= ENG_IDLE;
        default:  state <= ENG_IDLE;
      endcase
    end
  end

  // R7: no second word leaves the queue while an exchange is outstanding
  p_single_xfer_r7: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> !tx_pop);
  // R7: a presented word is held until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));
  // R5: words leave the transmit queue only while the port runs
  p_run_gate_r5: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> run);
  // R6: no receive push when the receive queue had no room at start
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (!rx_space && !in_flight) |-> !rx_push);
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              xchg_req_valid,
  input  logic              xchg_req_ready,
  output logic [DATA_W-1:0] xchg_req_data,
  input  logic              xchg_resp_valid,
  input  logic [DATA_W-1:0] xchg_resp_data
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] LVL_HALF = LVL_W'(FIFO_DEPTH / 2);

  logic [31:0] ctrl0, ctrl1, imask;
  logic [7:0]  presc;
  logic [DATA_W-1:0] word_mask, tx_head, rx_head, rx_word;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic tx_push, tx_pop, rx_push, rx_pop, in_flight;
  logic is_data, is_id;
  logic [4:0]  status;
  logic [3:0]  raw;
  logic [31:0] rd_mux;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign word_mask[i] = (i <= int'(ctrl0[3:0]));
  end

  assign is_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign is_id   = (bus_addr[ADDR_W-1:5] == '1);
  assign tx_push = bus_wr && is_data && (tx_level != LVL_FULL);
  assign rx_pop  = bus_rd && is_data && (rx_level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0 <= 32'h7;
      ctrl1 <= '0;
      imask <= '0;
      presc <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(OFF_CTRL0): ctrl0 <= bus_wdata;
        ADDR_W'(OFF_CTRL1): ctrl1 <= bus_wdata;
        ADDR_W'(OFF_IMASK): imask <= bus_wdata;
        ADDR_W'(OFF_PRESC): presc <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .push(tx_push), .push_data(bus_wdata[DATA_W-1:0] & word_mask),
    .pop(tx_pop), .head_data(tx_head), .level(tx_level)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_word),
    .pop(rx_pop), .head_data(rx_head), .level(rx_level)
  );

  ssp_xfer_engine #(.W(DATA_W)) eng_i (
    .clk(clk), .rst(rst),
    .run(ctrl1[1] && !ctrl1[2]), .loopback(ctrl1[0]),
    .tx_avail(tx_level != '0), .rx_space(rx_level != LVL_FULL),
    .tx_word(tx_head), .word_mask(word_mask),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .in_flight(in_flight),
    .req_valid(xchg_req_valid), .req_data(xchg_req_data), .req_ready(xchg_req_ready),
    .resp_valid(xchg_resp_valid), .resp_data(xchg_resp_data)
  );

  assign status = {(tx_level != '0) || in_flight, rx_level == LVL_FULL,
                   rx_level != '0, tx_level != LVL_FULL, tx_level == '0};
  assign raw    = {tx_level <= LVL_HALF, rx_level >= LVL_HALF, 2'b00};

  always_comb begin
    rd_mux = '0;
    if (is_id) begin
      rd_mux = {24'h0, id_byte(bus_addr[4:2])};
    end else begin
      case (bus_addr)
        ADDR_W'(OFF_CTRL0): rd_mux = ctrl0;
        ADDR_W'(OFF_CTRL1): rd_mux = ctrl1;
        ADDR_W'(OFF_DATA):  rd_mux = (rx_level != '0) ? 32'(rx_head) : 32'h0;
        ADDR_W'(OFF_STAT):  rd_mux = 32'(status);
        ADDR_W'(OFF_PRESC): rd_mux = 32'(presc);
        ADDR_W'(OFF_IMASK): rd_mux = imask;
        ADDR_W'(OFF_RAW):   rd_mux = 32'(raw);
        ADDR_W'(OFF_MIS):   rd_mux = 32'(raw & imask[3:0]);
        default:            rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= |(raw & imask[3:0]);
    end
  end

  // R3: a write into a full transmit queue is dropped
  p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_data && tx_level == LVL_FULL && !tx_pop) |=> (tx_level == LVL_FULL));
  // R4: reading an empty receive queue returns zero
  p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_data && rx_level == '0) |=> (bus_rdata == 32'h0));
  // R9: with a cleared mask the interrupt stays low
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(imask[3:2]) == 2'b00) |-> !irq);
  // R6: receive queue never exceeds its depth
  p_rx_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_FULL);
endmodule

// File: tb/ssp_ctrl_tb.sv
module ssp_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        req_valid, req_ready = 1'b0, resp_valid = 1'b0;
  logic [15:0] req_data, resp_data = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] caps [4];
  int n_caps = 0;

  always #4 clk = ~clk;

  ssp_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .xchg_req_valid(req_valid), .xchg_req_ready(req_ready), .xchg_req_data(req_data),
    .xchg_resp_valid(resp_valid), .xchg_resp_data(resp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exchange peer: accepts a word, answers with its complement after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        req_ready = 1'b1;
        if (n_caps < 4) caps[n_caps] = req_data;
        n_caps++;
        @(negedge clk); req_ready = 1'b0;
        repeat (5) @(negedge clk);
        resp_valid = 1'b1; resp_data = ~caps[n_caps-1];
        @(negedge clk); resp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] ids [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [15:0] words [3] = '{16'h003C, 16'h005A, 16'h0081};
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h00C, v); chk("R1 status", v, 32'h03);
    rd(12'h018, v); chk("R1 raw", v, 32'h08);
    rd(12'h014, v); chk("R1 mask", v, 32'h0);
    rd(12'h01C, v); chk("R1 masked", v, 32'h0);
    rd(12'h000, v); chk("R1 ctrl0", v, 32'h7);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R10 identification window
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), v); chk("R10 id", v, {24'h0, ids[i]});
    end

    // R11 prescaler, DMA, read-only registers
    wr(12'h010, 32'h1234); rd(12'h010, v); chk("R11 presc", v, 32'h34);
    wr(12'h020, 32'hFF); rd(12'h020, v); chk("R11 dma", v, 32'h0);
    wr(12'h00C, 32'hFF); wr(12'h018, 32'hFF); wr(12'h01C, 32'hFF);
    rd(12'h00C, v); chk("R11 status ro", v, 32'h03);
    rd(12'h018, v); chk("R11 raw ro", v, 32'h08);

    // R5 disabled: fill TX, R3 drop on full, R4 empty read
    for (int i = 0; i < 9; i++) wr(12'h008, 32'h1A0 + i);
    rd(12'h00C, v); chk("R3 R8 status full", v, 32'h10);
    rd(12'h018, v); chk("R9 raw tx full", v, 32'h0);
    rd(12'h008, v); chk("R4 empty read", v, 32'h0);

    // R6 loopback drains into RX until full, then stalls
    wr(12'h004, 32'h3); idle(12);
    rd(12'h00C, v); chk("R8 status rx full", v, 32'h0F);
    rd(12'h018, v); chk("R9 raw both", v, 32'h0C);
    wr(12'h014, 32'h4); idle(2);
    rd(12'h01C, v); chk("R9 masked", v, 32'h04);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    wr(12'h008, 32'h55); wr(12'h008, 32'h66); wr(12'h008, 32'h77); idle(4);
    rd(12'h00C, v); chk("R6 stall status", v, 32'h1E);
    for (int i = 0; i < 8; i++) begin
      rd(12'h008, v); chk("R12 R2 order", v, 32'hA0 + i);
    end
    rd(12'h008, v); chk("R6 stalled0", v, 32'h55);
    rd(12'h008, v); chk("R6 stalled1", v, 32'h66);
    rd(12'h008, v); chk("R6 stalled2", v, 32'h77);
    rd(12'h008, v); chk("R4 empty again", v, 32'h0);
    idle(2); chk("R9 irq low", {31'b0, irq}, 32'h0);

    // R2 width sweep in loopback
    for (int w = 0; w < 16; w++) begin
      logic [31:0] p;
      p = 32'(16'hBEEF ^ 16'(w * 16'h1357));
      wr(12'h000, 32'(w));
      wr(12'h008, p); idle(3);
      rd(12'h008, v); chk("R2 width", v, p & ((32'h1 << (w + 1)) - 1));
    end
    rd(12'h000, v); chk("R2 ctrl0 readback", v, 32'hF);

    // R9 threshold sweep
    wr(12'h004, 32'h0); wr(12'h000, 32'h7); wr(12'h014, 32'hC);
    for (int n = 1; n <= 8; n++) begin
      wr(12'h008, 32'(n)); idle(1);
      rd(12'h018, v); chk("R9 tx threshold", v, (n <= 4) ? 32'h8 : 32'h0);
      chk("R9 irq tx", {31'b0, irq}, (n <= 4) ? 32'h1 : 32'h0);
    end
    wr(12'h004, 32'h3); idle(12);
    for (int k = 8; k >= 1; k--) begin
      rd(12'h018, v); chk("R9 rx threshold", v, 32'h8 | ((k >= 4) ? 32'h4 : 32'h0));
      rd(12'h008, v); chk("R12 sweep order", v, 32'(9 - k));
    end
    rd(12'h018, v); chk("R9 rx empty", v, 32'h8);

    // R5 slave select blocks transfers
    wr(12'h004, 32'h7); wr(12'h008, 32'h42); idle(4);
    rd(12'h00C, v); chk("R5 slave hold", v, 32'h12);
    wr(12'h004, 32'h3); idle(4);
    rd(12'h008, v); chk("R5 released", v, 32'h42);

    // R7 external exchange, three back-to-back words
    wr(12'h004, 32'h2);
    for (int i = 0; i < 3; i++) wr(12'h008, 32'(words[i]));
    idle(4);
    rd(12'h00C, v); chk("R8 busy in flight", v & 32'h10, 32'h10);
    idle(40);
    chk("R7 exchange count", 32'(n_caps), 32'h3);
    for (int i = 0; i < 3; i++) begin
      chk("R7 presented word", 32'(caps[i]), 32'(words[i]));
      rd(12'h008, v); chk("R7 masked response", v, 32'(~words[i] & 16'hFF));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule